// File: doc/BRIEF.md
# Lazy FP Context Restore Sequencer

This block reloads the floating-point register file and the FP status/control word from a stack frame in memory when one restore command arrives. A single-cycle `start` pulse carries a 32-bit frame pointer together with a snapshot of five status inputs: secure state, secure FP context-active, coprocessor access permitted, lazy preservation pending and extended frame. The block sorts the command into one of five outcomes. It can skip the command, raise a no-coprocessor fault, clear the pending lazy flag, raise an unaligned-pointer fault, or run a full load through a one-word-at-a-time memory read port.

A full load reads 16 or 32 single-precision words from the frame. It packs each even/odd word pair into one 64-bit double register write. It then reads the status word and writes it out. The register slots above the first sixteen words sit past a two-word hole that holds the status word, so the upper half of an extended frame starts 8 bytes later than a packed layout would put it. A read error stops the sequence with a bus-fault pulse.

Each outcome ends in a one-cycle terminal pulse. The requested flag updates travel on the same cycle as that pulse, as one-cycle strobes (`lazy_clr`, `fpca_set`).

Top module: `fpctx_restore`

## Requirements
- R1: When a command starts with the secure-state input clear or the context-active input clear, `done` pulses in the next cycle. No memory read happens, no write happens, and neither flag strobe fires.
- R2: Otherwise, when coprocessor access is not permitted, `fault_nocp` pulses in the next cycle and no memory read is issued.
- R3: Otherwise, when lazy preservation is pending, `done`, `lazy_clr` and `fpca_set` pulse together in the next cycle and no memory read is issued.
- R4: Otherwise, when bits [2:0] of the frame pointer are not all zero, `fault_unalign` pulses in the next cycle and no memory read is issued.
- R5: Otherwise a load runs. It reads 32 words and writes 16 double registers when the extended-frame input is 1. It reads 16 words and writes 8 double registers when that input is 0.
- R6: Load word k (k counted from 0) is read from frame pointer + 4*k when k < 16, and from frame pointer + 4*k + 8 when k >= 16.
- R7: After word 2d+1 arrives, one register write fires with `rf_idx` = d and `rf_data` = {word 2d+1, word 2d}, so the high word sits in bits [63:32]. No write fires for a pair until both of its words have arrived.
- R8: After the last register word, the status word is read from frame pointer + 0x40 and presented on `stat_data` with a one-cycle `stat_we`.
- R9: A load that completes without error ends with `done` and `fpca_set` pulsing in the same cycle as `stat_we`.
- R10: `mem_req` is a one-cycle pulse, and no new request is issued until the previous one has received `mem_rvalid`.
- R11: `busy` is high from the cycle after an accepted load command until the terminal pulse, and is low in the terminal cycle. A `start` while the block is not idle has no effect.
- R12: A response with `mem_err` = 1 ends the load with `fault_bus`. No further read is issued, there is no status write, and `fpca_set` does not fire.
- R13: During and after reset, every output strobe and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restore command pulse |
| frame_ptr | input | 32 | Byte address of the saved frame |
| in_secure | input | 1 | Processor is in secure state |
| in_ctx_active | input | 1 | Secure FP context-active flag |
| in_cp_ok | input | 1 | Coprocessor access permitted at current privilege |
| in_lazy_pend | input | 1 | Lazy preservation still pending |
| in_ext_frame | input | 1 | Frame holds the upper 16 single-precision words |
| busy | output | 1 | Load sequence in progress |
| done | output | 1 | Command completed without fault |
| fault_nocp | output | 1 | No-coprocessor fault pulse |
| fault_unalign | output | 1 | Unaligned frame pointer fault pulse |
| fault_bus | output | 1 | Memory error fault pulse |
| lazy_clr | output | 1 | Clear the lazy-pending flag |
| fpca_set | output | 1 | Set the FP context-active flag |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Read response error |
| rf_we | output | 1 | Double register write strobe |
| rf_idx | output | 4 | Double register index |
| rf_data | output | 64 | Double register value |
| stat_we | output | 1 | Status word write strobe |
| stat_data | output | 32 | Status word value |

## Verification
Random commands draw every combination of the five status inputs with aligned and misaligned pointers. This separates the priority order between skip, no-coprocessor, lazy and alignment outcomes, because several conditions are often true at once. Load commands alternate between short and extended frames, with random response latency. This tells the 8-register layout from the 16-register layout and exposes any missing 8-byte hole above word 15. Every memory word's value depends on its address, so swapped pair halves or wrong register indices show up. Directed cases inject a read error on the first word, inside a pair and on the status read, and pulse `start` in the middle of a load to show that it is ignored.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE_SKIP,
        ST_DONE_LAZY,
        ST_DONE_LOAD,
        ST_F_NOCP,
        ST_F_ALIGN,
        ST_F_BUS
    } fsm_t;

    typedef enum logic [2:0] {
        ENTRY_SKIP,
        ENTRY_NOCP,
        ENTRY_LAZY,
        ENTRY_ALIGN,
        ENTRY_LOAD
    } entry_t;

    typedef struct packed {
        logic secure;
        logic ctx_active;
        logic cp_ok;
        logic lazy_pend;
        logic ext;
    } cmd_flags_t;

    // Priority of the command outcomes: skip, access, lazy, alignment, load.
    function automatic entry_t classify(input cmd_flags_t f, input logic misaligned);
        if (!f.secure || !f.ctx_active) return ENTRY_SKIP;
        if (!f.cp_ok)                   return ENTRY_NOCP;
        if (f.lazy_pend)                return ENTRY_LAZY;
        if (misaligned)                 return ENTRY_ALIGN;
        return ENTRY_LOAD;
    endfunction

    function automatic logic is_terminal(input fsm_t s);
        return (s == ST_DONE_SKIP) || (s == ST_DONE_LAZY) || (s == ST_DONE_LOAD) ||
               (s == ST_F_NOCP) || (s == ST_F_ALIGN) || (s == ST_F_BUS);
    endfunction

endpackage

// File: rtl/fpctx_ctrl.sv
module fpctx_ctrl
    import fpctx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BASE_WORDS = 16,
    parameter int EXT_WORDS  = 32,
    parameter int ALIGN_LSB  = 3,
    localparam int IDX_W     = $clog2(EXT_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] frame_ptr,
    input  cmd_flags_t        flags,
    input  logic              mem_rvalid,
    input  logic              mem_err,
    output fsm_t              state,
    output logic [IDX_W-1:0]  word_idx,
    output logic              stat_phase,
    output logic [ADDR_W-1:0] fp_q,
    output logic              accept
);

    localparam logic [IDX_W-1:0] LAST_BASE = IDX_W'(BASE_WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_EXT  = IDX_W'(EXT_WORDS - 1);

    logic             ext_q;
    logic             misaligned;
    entry_t           entry;
    logic [IDX_W-1:0] last_idx;

    assign misaligned = |frame_ptr[ALIGN_LSB-1:0];
    assign entry      = classify(flags, misaligned);
    assign last_idx   = ext_q ? LAST_EXT : LAST_BASE;
    assign accept     = (state == ST_WAIT) && mem_rvalid && !mem_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            word_idx   <= '0;
            stat_phase <= 1'b0;
            fp_q       <= '0;
            ext_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        unique case (entry)
                            ENTRY_SKIP:  state <= ST_DONE_SKIP;
                            ENTRY_NOCP:  state <= ST_F_NOCP;
                            ENTRY_LAZY:  state <= ST_DONE_LAZY;
                            ENTRY_ALIGN: state <= ST_F_ALIGN;
                            default: begin
                                state      <= ST_REQ;
                                word_idx   <= '0;
                                stat_phase <= 1'b0;
                                fp_q       <= frame_ptr;
                                ext_q      <= flags.ext;
                            end
                        endcase
                    end
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            state <= ST_F_BUS;
                        end else if (stat_phase) begin
                            state <= ST_DONE_LOAD;
                        end else if (word_idx == last_idx) begin
                            stat_phase <= 1'b1;
                            state      <= ST_REQ;
                        end else begin
                            word_idx <= word_idx + 1'b1;
                            state    <= ST_REQ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fpctx_addr_gen.sv
module fpctx_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int BASE_WORDS = 16,
    parameter int EXT_WORDS  = 32,
    parameter int GAP_BYTES  = 8,
    localparam int IDX_W     = $clog2(EXT_WORDS),
    localparam int STAT_OFS  = 4 * BASE_WORDS
) (
    input  logic [ADDR_W-1:0] fp_q,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic              stat_phase,
    output logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] word_ofs;
    logic [ADDR_W-1:0] gap_ofs;

    assign word_ofs = ADDR_W'({word_idx, 2'b00});

    generate
        if (GAP_BYTES > 0) begin : g_gap
            logic upper;
            assign upper   = (word_idx >= IDX_W'(BASE_WORDS));
            assign gap_ofs = upper ? ADDR_W'(GAP_BYTES) : '0;
        end else begin : g_nogap
            assign gap_ofs = '0;
        end
    endgenerate

    assign mem_addr = stat_phase ? (fp_q + ADDR_W'(STAT_OFS))
                                 : (fp_q + word_ofs + gap_ofs);

endmodule

// File: rtl/fpctx_pair_asm.sv
module fpctx_pair_asm
    import fpctx_pkg::*;
#(
    parameter int EXT_WORDS = 32,
    localparam int IDX_W    = $clog2(EXT_WORDS),
    localparam int DREG_W   = IDX_W - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                stat_phase,
    input  logic [IDX_W-1:0]    word_idx,
    input  logic [WORD_W-1:0]   rdata,
    output logic                rf_we,
    output logic [DREG_W-1:0]   rf_idx,
    output logic [2*WORD_W-1:0] rf_data,
    output logic                stat_we,
    output logic [WORD_W-1:0]   stat_data
);

    logic [WORD_W-1:0] lo_q;
    logic              take_lo;
    logic              take_hi;
    logic              take_stat;

    assign take_stat = accept && stat_phase;
    assign take_lo   = accept && !stat_phase && !word_idx[0];
    assign take_hi   = accept && !stat_phase && word_idx[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q      <= '0;
            rf_we     <= 1'b0;
            rf_idx    <= '0;
            rf_data   <= '0;
            stat_we   <= 1'b0;
            stat_data <= '0;
        end else begin
            rf_we   <= take_hi;
            stat_we <= take_stat;
            if (take_lo) lo_q <= rdata;
            if (take_hi) begin
                rf_idx  <= word_idx[IDX_W-1:1];
                rf_data <= {rdata, lo_q};
            end
            if (take_stat) stat_data <= rdata;
        end
    end

endmodule

// File: rtl/fpctx_restore.sv
module fpctx_restore
    import fpctx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BASE_WORDS = 16,
    parameter int EXT_WORDS  = 32,
    parameter int GAP_BYTES  = 8,
    parameter int ALIGN_LSB  = 3,
    localparam int IDX_W     = $clog2(EXT_WORDS),
    localparam int DREG_W    = IDX_W - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   frame_ptr,
    input  logic                in_secure,
    input  logic                in_ctx_active,
    input  logic                in_cp_ok,
    input  logic                in_lazy_pend,
    input  logic                in_ext_frame,
    output logic                busy,
    output logic                done,
    output logic                fault_nocp,
    output logic                fault_unalign,
    output logic                fault_bus,
    output logic                lazy_clr,
    output logic                fpca_set,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_err,
    output logic                rf_we,
    output logic [DREG_W-1:0]   rf_idx,
    output logic [2*WORD_W-1:0] rf_data,
    output logic                stat_we,
    output logic [WORD_W-1:0]   stat_data
);

    cmd_flags_t        flags;
    fsm_t              state;
    logic [IDX_W-1:0]  word_idx;
    logic              stat_phase;
    logic [ADDR_W-1:0] fp_q;
    logic              accept;

    assign flags = '{secure:     in_secure,
                     ctx_active: in_ctx_active,
                     cp_ok:      in_cp_ok,
                     lazy_pend:  in_lazy_pend,
                     ext:        in_ext_frame};

    fpctx_ctrl #(
        .ADDR_W     (ADDR_W),
        .BASE_WORDS (BASE_WORDS),
        .EXT_WORDS  (EXT_WORDS),
        .ALIGN_LSB  (ALIGN_LSB)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .frame_ptr  (frame_ptr),
        .flags      (flags),
        .mem_rvalid (mem_rvalid),
        .mem_err    (mem_err),
        .state      (state),
        .word_idx   (word_idx),
        .stat_phase (stat_phase),
        .fp_q       (fp_q),
        .accept     (accept)
    );

    fpctx_addr_gen #(
        .ADDR_W     (ADDR_W),
        .BASE_WORDS (BASE_WORDS),
        .EXT_WORDS  (EXT_WORDS),
        .GAP_BYTES  (GAP_BYTES)
    ) u_addr (
        .fp_q       (fp_q),
        .word_idx   (word_idx),
        .stat_phase (stat_phase),
        .mem_addr   (mem_addr)
    );

    fpctx_pair_asm #(
        .EXT_WORDS  (EXT_WORDS)
    ) u_pair (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .stat_phase (stat_phase),
        .word_idx   (word_idx),
        .rdata      (mem_rdata),
        .rf_we      (rf_we),
        .rf_idx     (rf_idx),
        .rf_data    (rf_data),
        .stat_we    (stat_we),
        .stat_data  (stat_data)
    );

    assign mem_req       = (state == ST_REQ);
    assign busy          = (state == ST_REQ) || (state == ST_WAIT);
    assign done          = (state == ST_DONE_SKIP) || (state == ST_DONE_LAZY) ||
                           (state == ST_DONE_LOAD);
    assign lazy_clr      = (state == ST_DONE_LAZY);
    assign fpca_set      = (state == ST_DONE_LAZY) || (state == ST_DONE_LOAD);
    assign fault_nocp    = (state == ST_F_NOCP);
    assign fault_unalign = (state == ST_F_ALIGN);
    assign fault_bus     = (state == ST_F_BUS);

endmodule

// File: rtl/fpctx_restore_chk.sv
module fpctx_restore_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              fault_nocp,
    input logic              fault_unalign,
    input logic              fault_bus,
    input logic              lazy_clr,
    input logic              fpca_set,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              rf_we,
    input logic              stat_we
);

    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)             outstanding <= 1'b0;
        else if (mem_req)    outstanding <= 1'b1;
        else if (mem_rvalid) outstanding <= 1'b0;
    end

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !outstanding);

    a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r6_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r11_single_terminal: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, fault_nocp, fault_unalign, fault_bus}));

    a_r11_not_busy_at_end: assert property (@(posedge clk) disable iff (rst)
        (done || fault_nocp || fault_unalign || fault_bus) |-> !busy);

    a_r9_fpca_with_done: assert property (@(posedge clk) disable iff (rst)
        fpca_set |-> done);

    a_r8_stat_ends_load: assert property (@(posedge clk) disable iff (rst)
        stat_we |-> (done && fpca_set));

    a_r3_lazy_sets_fpca: assert property (@(posedge clk) disable iff (rst)
        lazy_clr |-> (done && fpca_set && !stat_we));

    a_r12_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        fault_bus |-> (!fpca_set && !stat_we && !rf_we));

endmodule

bind fpctx_restore fpctx_restore_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .fault_nocp    (fault_nocp),
    .fault_unalign (fault_unalign),
    .fault_bus     (fault_bus),
    .lazy_clr      (lazy_clr),
    .fpca_set      (fpca_set),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rvalid    (mem_rvalid),
    .rf_we         (rf_we),
    .stat_we       (stat_we)
);

// File: tb/fpctx_restore_tb.sv
module fpctx_restore_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] frame_ptr = '0;
    logic        in_secure = 1'b0, in_ctx_active = 1'b0, in_cp_ok = 1'b0;
    logic        in_lazy_pend = 1'b0, in_ext_frame = 1'b0;
    logic        busy, done, fault_nocp, fault_unalign, fault_bus, lazy_clr, fpca_set;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        rf_we;
    logic [3:0]  rf_idx;
    logic [63:0] rf_data;
    logic        stat_we;
    logic [31:0] stat_data;

    fpctx_restore u_dut (
        .clk(clk), .rst(rst), .start(start), .frame_ptr(frame_ptr),
        .in_secure(in_secure), .in_ctx_active(in_ctx_active), .in_cp_ok(in_cp_ok),
        .in_lazy_pend(in_lazy_pend), .in_ext_frame(in_ext_frame),
        .busy(busy), .done(done), .fault_nocp(fault_nocp), .fault_unalign(fault_unalign),
        .fault_bus(fault_bus), .lazy_clr(lazy_clr), .fpca_set(fpca_set),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
        .stat_we(stat_we), .stat_data(stat_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Logs filled by responder and monitor.
    logic [31:0] salt = 32'h1357_9bdf;
    int          err_at = -1;
    int          n_req = 0;
    logic [31:0] req_addr [0:63];
    int          n_rf = 0;
    logic [3:0]  rf_idx_log [0:63];
    logic [63:0] rf_data_log [0:63];
    int          n_stat = 0;
    logic [31:0] stat_log;
    int          n_fpca = 0;
    int          n_lazy = 0;
    int          term_code = -1;
    int          overlap_err = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ salt;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] fp, input int k, input int nw);
        if (k == nw) return fp + 32'h40;
        if (k < 16)  return fp + 32'(4 * k);
        return fp + 32'(4 * k + 8);
    endfunction

    // Memory responder: 1 to 3 cycles of latency, one outstanding read expected.
    initial begin
        int lat = 0;
        logic pend = 1'b0;
        logic [31:0] paddr = '0;
        int pord = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_err    = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_word(paddr);
                    mem_err    = (pord == err_at);
                    pend       = 1'b0;
                end else begin
                    lat--;
                end
            end
            if (mem_req) begin
                if (pend) overlap_err++;
                pend  = 1'b1;
                lat   = $urandom_range(0, 2);
                paddr = mem_addr;
                pord  = n_req;
                if (n_req < 64) req_addr[n_req] = mem_addr;
                n_req++;
            end
        end
    end

    // Output monitor.
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (!rst) begin
                if (rf_we) begin
                    if (n_rf < 64) begin
                        rf_idx_log[n_rf]  = rf_idx;
                        rf_data_log[n_rf] = rf_data;
                    end
                    n_rf++;
                end
                if (stat_we) begin stat_log = stat_data; n_stat++; end
                if (fpca_set) n_fpca++;
                if (lazy_clr) n_lazy++;
                if (fault_nocp)         term_code = 1;
                else if (fault_unalign) term_code = 3;
                else if (fault_bus)     term_code = 5;
                else if (done && lazy_clr) term_code = 2;
                else if (done && fpca_set) term_code = 4;
                else if (done)          term_code = 0;
            end
        end
    end

    task automatic run_cmd(input logic [31:0] fp, input logic sec, input logic ctx,
                           input logic cp, input logic lz, input logic ext,
                           input int e_at, input logic poke);
        int nw, ecode, exp_req, exp_rf, exp_stat, exp_fpca, exp_lazy, iter;
        string rq;
        nw = ext ? 32 : 16;
        if (!sec || !ctx)        ecode = 0;
        else if (!cp)            ecode = 1;
        else if (lz)             ecode = 2;
        else if (fp[2:0] != 0)   ecode = 3;
        else if (e_at >= 0 && e_at <= nw) ecode = 5;
        else                     ecode = 4;
        exp_req  = (ecode == 4) ? nw + 1 : (ecode == 5) ? e_at + 1 : 0;
        exp_rf   = (ecode == 4) ? nw / 2 : (ecode == 5) ? e_at / 2 : 0;
        exp_stat = (ecode == 4) ? 1 : 0;
        exp_fpca = (ecode == 4 || ecode == 2) ? 1 : 0;
        exp_lazy = (ecode == 2) ? 1 : 0;
        rq = (ecode == 0) ? "R1" : (ecode == 1) ? "R2" : (ecode == 2) ? "R3" :
             (ecode == 3) ? "R4" : (ecode == 5) ? "R12" : "R5";

        @(negedge clk);
        salt = $urandom;
        err_at = e_at;
        n_req = 0; n_rf = 0; n_stat = 0; n_fpca = 0; n_lazy = 0; term_code = -1;
        start = 1'b1; frame_ptr = fp;
        in_secure = sec; in_ctx_active = ctx; in_cp_ok = cp;
        in_lazy_pend = lz; in_ext_frame = ext;
        @(negedge clk);
        start = 1'b0;
        // R11: busy only for load commands, one cycle after start.
        chk(busy == (ecode >= 4), "R11", "busy after start", busy, (ecode >= 4));
        iter = 0;
        while (term_code < 0 && iter < 600) begin
            @(negedge clk);
            iter++;
            if (poke && iter == 5 && busy) begin
                // R11: a command that would fault if accepted.
                start = 1'b1; frame_ptr = 32'h3; in_cp_ok = 1'b0;
                @(negedge clk);
                start = 1'b0;
            end
        end
        repeat (4) @(negedge clk);
        chk(term_code == ecode, rq, "outcome", term_code, ecode);
        chk(n_req == exp_req, (ecode == 5) ? "R12" : "R5", "read count", n_req, exp_req);
        for (int k = 0; k < exp_req && k < n_req && k < 64; k++)
            chk(req_addr[k] == exp_addr(fp, k, nw), (k == nw) ? "R8" : "R6",
                "read address", req_addr[k], exp_addr(fp, k, nw));
        chk(n_rf == exp_rf, "R7", "register writes", n_rf, exp_rf);
        for (int d = 0; d < exp_rf && d < n_rf; d++) begin
            chk(rf_idx_log[d] == 4'(d), "R7", "register index", rf_idx_log[d], d);
            chk(rf_data_log[d] == {mem_word(exp_addr(fp, 2*d+1, nw)), mem_word(exp_addr(fp, 2*d, nw))},
                "R7", "register data", rf_data_log[d],
                {mem_word(exp_addr(fp, 2*d+1, nw)), mem_word(exp_addr(fp, 2*d, nw))});
        end
        chk(n_stat == exp_stat, "R8", "status writes", n_stat, exp_stat);
        if (exp_stat == 1 && n_stat == 1)
            chk(stat_log == mem_word(fp + 32'h40), "R8", "status data", stat_log, mem_word(fp + 32'h40));
        chk(n_fpca == exp_fpca, (ecode == 5) ? "R12" : "R9", "fpca_set pulses", n_fpca, exp_fpca);
        chk(n_lazy == exp_lazy, "R3", "lazy_clr pulses", n_lazy, exp_lazy);
        chk(overlap_err == 0, "R10", "request while outstanding", overlap_err, 0);
        err_at = -1;
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R13: reset state.
        chk({busy, done, fault_nocp, fault_unalign, fault_bus, lazy_clr, fpca_set,
             mem_req, rf_we, stat_we} == 10'b0, "R13", "outputs in reset",
            {busy, done, fault_nocp, fault_unalign, fault_bus, lazy_clr, fpca_set,
             mem_req, rf_we, stat_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, mem_req, rf_we, stat_we, fpca_set} == 6'b0, "R13", "outputs after reset",
            {busy, done, mem_req, rf_we, stat_we, fpca_set}, 0);

        // Directed corners.
        run_cmd(32'h2000_0100, 1, 0, 1, 0, 1, -1, 0);  // R1 context clear
        run_cmd(32'h2000_0100, 0, 1, 1, 0, 1, -1, 0);  // R1 non-secure
        run_cmd(32'h2000_0104, 1, 1, 0, 1, 1, -1, 0);  // R2 beats lazy and alignment
        run_cmd(32'h2000_0104, 1, 1, 1, 1, 0, -1, 0);  // R3 beats alignment
        run_cmd(32'h2000_0104, 1, 1, 1, 0, 0, -1, 0);  // R4
        run_cmd(32'h2000_0101, 1, 1, 1, 0, 1, -1, 0);  // R4 odd byte
        run_cmd(32'h2000_0200, 1, 1, 1, 0, 0, -1, 0);  // R5 short frame
        run_cmd(32'h2000_0300, 1, 1, 1, 0, 1, -1, 1);  // R6 extended, R11 poke
        run_cmd(32'h2000_0400, 1, 1, 1, 0, 1, 0, 0);   // R12 first word
        run_cmd(32'h2000_0400, 1, 1, 1, 0, 1, 7, 0);   // R12 high half of a pair
        run_cmd(32'h2000_0400, 1, 1, 1, 0, 0, 16, 0);  // R12 status read
        run_cmd(32'hFFFF_FFB8, 1, 1, 1, 0, 1, -1, 0);  // R6 address wrap

        // Random commands.
        for (int i = 0; i < 70; i++) begin
            logic [31:0] fp;
            logic ext;
            int e;
            fp  = $urandom;
            if ($urandom_range(0, 3) != 0) fp[2:0] = 3'b000;
            ext = 1'($urandom_range(0, 1));
            e   = ($urandom_range(0, 5) == 0) ? $urandom_range(0, ext ? 32 : 16) : -1;
            run_cmd(fp, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
                    ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) == 0), ext, e,
                    ($urandom_range(0, 4) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule